// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt lines from a small processor subsystem and drives one active-low interrupt request to the CPU. Each line has its own mode word, which holds a 3-bit priority and a 2-bit sensitivity code, and its own 32-bit vector word. Every input passes through a two-stage synchroniser. Edge-type lines then set a sticky pending latch, while level-type lines are pending for as long as the synchronised input is active.

Software services an interrupt by reading the vector register. The read returns the vector of the winning source and also acknowledges it: the winner's priority is pushed onto a nesting stack that is eight entries deep, and the edge latch of that source is cleared. A write to the end-of-interrupt register pops one stack level. While a source is in service, only sources of strictly higher priority can raise the request line again. If no source qualifies when the vector register is read, the read returns the programmed spurious vector.

The register bus is word-addressed, with one-cycle read and write strobes. Read data appears on the cycle after the read strobe. There is no stream traffic, so every port is a plain control or status pin.

Top module: `irq_vector_ctrl`

Word map: mode words at 0x00+n, with priority in bits 2:0 and sensitivity in bits 5:4. Vector words at 0x20+n. The registers in the 0x40 block are:
- 0x40: vector (read)
- 0x41: in-service source (read)
- 0x43: pending (read)
- 0x44: enable mask (read)
- 0x48: enable (write)
- 0x49: disable (write)
- 0x4A: clear (write)
- 0x4B: end of interrupt (write)
- 0x4C: spurious vector (read/write)

## Requirements
- R1: A read of 0x40 returns the vector word of the enabled pending source with the highest priority (7 highest, 0 lowest), provided that priority is strictly above the top stack level, or the stack is empty. On equal priority the lowest source number wins.
- R2: A read of 0x40 with no qualifying source returns the 0x4C value, pushes nothing, and makes 0x41 read 0 until the next acknowledge or end of interrupt.
- R3: After an acknowledge, 0x41 reads the source number at the top of the stack. It reads 0 when the stack is empty.
- R4: Any write to 0x4B pops one level whatever the data. Eight pops fully unwind an eight-deep stack, so 0x41 then reads 0.
- R5: irq_n is low exactly when an enabled pending source outranks the top stack level, or when the stack is empty and any enabled source is pending.
- R6: A 1 written to a bit of 0x48 sets that enable bit, and a 1 written to a bit of 0x49 clears it. A 0 written to either register leaves the bit unchanged. 0x44 reads the enable mask.
- R7: Writing 1 to a bit of 0x4A clears that source's edge latch.
- R8: For an edge-type source, the pending latch clears when that source is acknowledged. For a level-type source, the pending state follows the synchronised input.
- R9: The sensitivity codes are 0 for level high, 1 for rising edge, 2 for level low and 3 for falling edge. Codes 2 and 3 act as written only on sources set in EXT_MASK (default sources 2 and 3). On any other source, code 2 acts as level high and code 3 acts as rising edge.
- R10: The stack nests up to eight levels, and pushed levels strictly increase toward the top.
- R11: After reset, irq_n is high, the enable mask, the pending bits, the spurious vector and 0x41 all read 0, and every mode word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Raw interrupt lines, asynchronous |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that bus_wr and bus_rd never assert in the same cycle. They also assume that software never acknowledges a source whose priority fails to outrank the top stack level, which the vector read guarantees. The bench drives the bus only through tasks that raise a single strobe for one cycle. It changes source lines only between bus operations and holds each change for several cycles, which keeps every edge visible through the synchroniser.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    SENSE_HIGH = 2'd0,
    SENSE_RISE = 2'd1,
    SENSE_LOW  = 2'd2,
    SENSE_FALL = 2'd3
  } sense_e;

  localparam logic [7:0] A_VEC_BASE = 8'h20;
  localparam logic [7:0] A_IVR      = 8'h40;
  localparam logic [7:0] A_ISR      = 8'h41;
  localparam logic [7:0] A_PEND     = 8'h43;
  localparam logic [7:0] A_ENMASK   = 8'h44;
  localparam logic [7:0] A_ENSET    = 8'h48;
  localparam logic [7:0] A_ENCLR    = 8'h49;
  localparam logic [7:0] A_LATCLR   = 8'h4A;
  localparam logic [7:0] A_EOI      = 8'h4B;
  localparam logic [7:0] A_SPUR     = 8'h4C;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell #(
  parameter bit IS_EXT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_i,
  input  logic [1:0] sense_i,
  input  logic       clr_i,
  input  logic       ack_i,
  output logic       pend_o
);
  logic [1:0] eff;
  logic s1, s2, s3;
  logic latch_q;
  logic edge_evt;

  // Sources not marked external only get high / rising behaviour.
  assign eff = IS_EXT ? sense_i : {1'b0, sense_i[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb begin
    edge_evt = 1'b0;
    if (eff[0]) edge_evt = eff[1] ? (s3 & ~s2) : (s2 & ~s3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                latch_q <= 1'b0;
    else if (edge_evt)         latch_q <= 1'b1;
    else if (clr_i || ack_i)   latch_q <= 1'b0;
  end

  assign pend_o = eff[0] ? latch_q : (s2 ^ eff[1]);

  a_r8_ack_clears_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !edge_evt) |=> !latch_q);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !edge_evt) |=> !latch_q);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]             req_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  output logic                        any_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic [PRIO_W-1:0]           prio_o
);
  // Scan from the top index down; ">=" lets the lower index win a tie.
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i] && (!any_o || prio_i[i] >= prio_o)) begin
        any_o  = 1'b1;
        idx_o  = IDX_W'(i);
        prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 5,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] lvl_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              empty_o,
  output logic              full_o,
  output logic [PRIO_W-1:0] top_lvl_o,
  output logic [IDX_W-1:0]  top_idx_o
);
  logic [SP_W-1:0]   sp_q;
  logic [PRIO_W-1:0] lvl_q [DEPTH];
  logic [IDX_W-1:0]  idx_q [DEPTH];
  logic [PTR_W-1:0]  top_ptr, wr_ptr;

  assign empty_o   = (sp_q == '0);
  assign full_o    = (sp_q == SP_W'(DEPTH));
  assign top_ptr   = PTR_W'(sp_q - 1'b1);
  assign wr_ptr    = PTR_W'(sp_q);
  assign top_lvl_o = empty_o ? '0 : lvl_q[top_ptr];
  assign top_idx_o = empty_o ? '0 : idx_q[top_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        lvl_q[i] <= '0;
        idx_q[i] <= '0;
      end
    end else if (pop_i) begin
      if (!empty_o) sp_q <= sp_q - 1'b1;
    end else if (push_i && !full_o) begin
      lvl_q[wr_ptr] <= lvl_i;
      idx_q[wr_ptr] <= idx_i;
      sp_q          <= sp_q + 1'b1;
    end
  end

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH));
  a_r4_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_o) |=> sp_q == $past(sp_q) - 1'b1);
  a_r10_strict_push: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !empty_o) |-> lvl_i > top_lvl_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int          NSRC     = 32,
  parameter int          PRIO_W   = 3,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 8,
  parameter int          DEPTH    = 8,
  parameter logic [31:0] EXT_MASK = 32'h0000_000C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int SNS_HI = PRIO_W + 2;

  logic [1:0]                  sense_q [NSRC];
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [DATA_W-1:0]           vec_q   [NSRC];
  logic [NSRC-1:0]             en_q, pend, ack_vec, clr_vec;
  logic [DATA_W-1:0]           spur_q, rdata_q, rd_mux;
  logic                        spur_flag_q;

  logic                        arb_any;
  logic [IDX_W-1:0]            arb_idx, top_idx;
  logic [PRIO_W-1:0]           arb_prio, top_lvl;
  logic                        stk_empty, stk_full;
  logic                        qualify, ivr_rd, ack, eoi_wr;
  logic                        in_mode, in_vec;
  logic [IDX_W-1:0]            sel;

  // ---------------- address decode ----------------
  assign sel     = bus_addr[IDX_W-1:0];
  assign in_mode = (int'(bus_addr) < NSRC);
  assign in_vec  = (bus_addr >= ADDR_W'(A_VEC_BASE)) &&
                   (int'(bus_addr) < int'(A_VEC_BASE) + NSRC);
  assign ivr_rd  = bus_rd && (bus_addr == ADDR_W'(A_IVR));
  assign eoi_wr  = bus_wr && (bus_addr == ADDR_W'(A_EOI));
  assign clr_vec = (bus_wr && bus_addr == ADDR_W'(A_LATCLR)) ? bus_wdata[NSRC-1:0] : '0;

  // ---------------- per-source front ends ----------------
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    vic_src_cell #(.IS_EXT(EXT_MASK[g])) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (src_i[g]),
      .sense_i (sense_q[g]),
      .clr_i   (clr_vec[g]),
      .ack_i   (ack_vec[g]),
      .pend_o  (pend[g])
    );
  end

  vic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i  (pend & en_q),
    .prio_i (prio_q),
    .any_o  (arb_any),
    .idx_o  (arb_idx),
    .prio_o (arb_prio)
  );

  assign qualify = arb_any && !stk_full && (stk_empty || arb_prio > top_lvl);
  assign ack     = ivr_rd && qualify;
  assign irq_n   = ~qualify;

  always_comb begin
    ack_vec = '0;
    if (ack) ack_vec[arb_idx] = 1'b1;
  end

  vic_nest_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (ack),
    .pop_i     (eoi_wr),
    .lvl_i     (arb_prio),
    .idx_i     (arb_idx),
    .empty_o   (stk_empty),
    .full_o    (stk_full),
    .top_lvl_o (top_lvl),
    .top_idx_o (top_idx)
  );

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        sense_q[i] <= SENSE_HIGH;
        prio_q[i]  <= '0;
        vec_q[i]   <= '0;
      end
      en_q        <= '0;
      spur_q      <= '0;
      spur_flag_q <= 1'b0;
    end else begin
      if (bus_wr && in_mode) begin
        prio_q[sel]  <= bus_wdata[PRIO_W-1:0];
        sense_q[sel] <= bus_wdata[SNS_HI -: 2];
      end
      if (bus_wr && in_vec)                         vec_q[sel] <= bus_wdata;
      if (bus_wr && bus_addr == ADDR_W'(A_SPUR))    spur_q <= bus_wdata;
      if (bus_wr && bus_addr == ADDR_W'(A_ENSET))   en_q <= en_q | bus_wdata[NSRC-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_ENCLR))   en_q <= en_q & ~bus_wdata[NSRC-1:0];
      if (ack || eoi_wr)    spur_flag_q <= 1'b0;
      else if (ivr_rd)      spur_flag_q <= 1'b1;
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    rd_mux = '0;
    if (in_mode) begin
      rd_mux[PRIO_W-1:0]  = prio_q[sel];
      rd_mux[SNS_HI -: 2] = sense_q[sel];
    end else if (in_vec) begin
      rd_mux = vec_q[sel];
    end else begin
      case (bus_addr)
        ADDR_W'(A_IVR):    rd_mux = qualify ? vec_q[arb_idx] : spur_q;
        ADDR_W'(A_ISR):    if (!stk_empty && !spur_flag_q) rd_mux[IDX_W-1:0] = top_idx;
        ADDR_W'(A_PEND):   rd_mux[NSRC-1:0] = pend;
        ADDR_W'(A_ENMASK): rd_mux[NSRC-1:0] = en_q;
        ADDR_W'(A_SPUR):   rd_mux = spur_q;
        default:           rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;

  a_r6_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_ENSET)) |=>
      ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_ENCLR)) |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));
  a_r5_irq_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ((pend & en_q) != '0));
  a_r2_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ivr_rd && irq_n) |=> spur_flag_q);
  a_r11_no_strobe_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n;
  int          nchk = 0, nerr = 0;

  localparam logic [31:0] EXT = 32'h0000_000C;

  always #2.5 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
  );

  // {source[9:5], sensitivity code[4:3], priority[2:0]}
  localparam logic [9:0] TBL [8] = '{
    {5'd1, 2'd0, 3'd3}, {5'd9, 2'd1, 3'd5}, {5'd2, 2'd2, 3'd1}, {5'd3, 2'd3, 3'd6},
    {5'd5, 2'd3, 3'd4}, {5'd8, 2'd2, 3'd2}, {5'd31, 2'd0, 3'd7}, {5'd20, 2'd1, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle(3); rst_n = 1'b1; idle(2);

    // R11 reset state
    chk("R11 irq_n", {31'd0, irq_n}, 32'd1);
    bread(8'h44, d); chk("R11 enable mask", d, 0);
    bread(8'h43, d); chk("R11 pending", d, 0);
    bread(8'h41, d); chk("R11 status", d, 0);
    bread(8'h07, d); chk("R11 mode word", d, 0);
    bread(8'h40, d); chk("R2 spurious default", d, 0);

    // R2 programmed spurious vector
    bwrite(8'h4C, 32'hDEAD_0001);
    bread(8'h40, d); chk("R2 spurious vector", d, 32'hDEAD_0001);
    bread(8'h41, d); chk("R2 status after spurious", d, 0);

    // R6 enable/disable with zero bits
    bwrite(8'h48, 32'h0000_000F);
    bwrite(8'h48, 32'h0);
    bread(8'h44, d); chk("R6 enable zero no effect", d, 32'hF);
    bwrite(8'h49, 32'h0);
    bread(8'h44, d); chk("R6 disable zero no effect", d, 32'hF);
    bwrite(8'h49, 32'h5);
    bread(8'h44, d); chk("R6 disable bits", d, 32'hA);
    bwrite(8'h49, 32'hFFFF_FFFF);

    // Table: single-source service per sensitivity and source kind (R1 R3 R5 R8 R9)
    for (int e = 0; e < 8; e++) begin
      logic [4:0] s; logic [1:0] sn; logic [2:0] p; logic [1:0] eff; logic inact;
      s = TBL[e][9:5]; sn = TBL[e][4:3]; p = TBL[e][2:0];
      eff = EXT[s] ? sn : {1'b0, sn[0]};
      inact = eff[1];
      src[s] = inact; idle(4);
      bwrite({3'd0, s}, {26'd0, sn, 1'b0, p});
      bwrite(8'h20 + {3'd0, s}, 32'h100 + {27'd0, s});
      bwrite(8'h48, 32'd1 << s);
      idle(2);
      chk("R5 idle irq_n high", {31'd0, irq_n}, 32'd1);
      src[s] = ~inact; idle(5);
      chk("R9 active irq_n low", {31'd0, irq_n}, 32'd0);
      bread(8'h40, d); chk("R1 vector", d, 32'h100 + {27'd0, s});
      bread(8'h41, d); chk("R3 status source", d, {27'd0, s});
      if (!eff[0]) begin src[s] = inact; idle(5); end
      bwrite(8'h4B, 32'hFFFF_FFFF);
      idle(1);
      chk("R8 released after service", {31'd0, irq_n}, 32'd1);
      bwrite(8'h49, 32'd1 << s);
      src[s] = 1'b0; idle(4);
      bwrite(8'h4A, 32'd1 << s);
      bwrite({3'd0, s}, 32'd0);
    end

    // Tie and equal priority: sources 4 and 6 at priority 2, level high
    bwrite(8'h04, 32'h2); bwrite(8'h06, 32'h2);
    bwrite(8'h24, 32'h404); bwrite(8'h26, 32'h406);
    bwrite(8'h48, 32'h50);
    src[4] = 1'b1; src[6] = 1'b1; idle(5);
    bread(8'h40, d); chk("R1 tie lowest number", d, 32'h404);
    chk("R5 equal priority blocked", {31'd0, irq_n}, 32'd1);
    bwrite(8'h4B, 0); idle(1);
    chk("R5 request after pop", {31'd0, irq_n}, 32'd0);
    bread(8'h40, d); chk("R8 level still pending", d, 32'h404);
    src[4] = 1'b0; idle(5);
    bwrite(8'h4B, 0);
    bread(8'h40, d); chk("R1 next source", d, 32'h406);
    bread(8'h40, d); chk("R2 spurious while in service", d, 32'hDEAD_0001);
    bread(8'h41, d); chk("R2 status zero after spurious", d, 0);
    src[6] = 1'b0; idle(5);
    bwrite(8'h4B, 0); idle(1);
    chk("R4 released", {31'd0, irq_n}, 32'd1);
    bwrite(8'h49, 32'h50);

    // Eight-level nesting: sources 10..17 rising edge, priority 0..7
    for (int k = 0; k < 8; k++) begin
      bwrite(8'(10 + k), {26'd0, 2'd1, 1'b0, 3'(k)});
      bwrite(8'(8'h20 + 10 + k), 32'h200 + 32'(k));
    end
    bwrite(8'd18, {26'd0, 2'd1, 1'b0, 3'd7});
    bwrite(8'h48, 32'h0007_FC00);
    for (int k = 0; k < 8; k++) begin
      src[10 + k] = 1'b1; idle(2); src[10 + k] = 1'b0; idle(4);
      chk("R10 deeper level raises irq", {31'd0, irq_n}, 32'd0);
      bread(8'h40, d); chk("R10 nested vector", d, 32'h200 + 32'(k));
    end
    chk("R10 full stack irq high", {31'd0, irq_n}, 32'd1);
    bread(8'h41, d); chk("R3 top status", d, 32'd17);
    src[18] = 1'b1; idle(2); src[18] = 1'b0; idle(4);
    chk("R5 not above top level", {31'd0, irq_n}, 32'd1);
    bwrite(8'h4B, 32'h1234);
    bread(8'h41, d); chk("R4 one pop", d, 32'd16);
    chk("R5 outranks after pop", {31'd0, irq_n}, 32'd0);
    for (int k = 0; k < 7; k++) bwrite(8'h4B, 0);
    bread(8'h41, d); chk("R4 eight pops unwind", d, 0);
    bread(8'h43, d); chk("R7 latch before clear", d, 32'h0004_0000);
    bwrite(8'h4A, 32'h0004_0000);
    bread(8'h43, d); chk("R7 latch cleared", d, 0);
    chk("R4 irq released", {31'd0, irq_n}, 32'd1);

    // Start-up style mask and clear
    bwrite(8'h49, 32'hFFFF_FFFF);
    bwrite(8'h4A, 32'hFFFF_FFFF);
    bread(8'h44, d); chk("R6 all disabled", d, 0);
    finish_run();
  end
endmodule